// File: doc/BRIEF.md
# Mode-Controlled Multi-Ratio Clock Divider

This block takes one fast reference clock, which stands for an already multiplied PLL output, and divides it into three related domains: a core domain, a bus domain and a peripheral domain. Each domain comes out in two forms. One is a single-reference-cycle enable pulse per divided period, and the other is a counter-derived level that forms a square wave. A small frequency-control register holds the multiplier setting (x8 or x12), the core ratio and the peripheral ratio. The bus ratio is never written. It follows from the multiplier setting and from two mode pins, which are latched while reset is held.

Each register write is checked against two rules before it is taken: the core must not run slower than the bus, and the peripheral must run at no more than half the bus rate. A write that breaks a rule is dropped and an error flag is raised. An accepted write waits in a pending slot. It goes live only on a cycle where all three divider counters reach their last count together, so every output restarts in phase and no shortened pulse appears.

Top module: `mcr_clock_divider`

## Requirements
- R1: After synchronous reset the live settings are x8, core divide-by-1 and peripheral divide-by-4, read back as `act_cfg` = 0. This default applies whatever the mode. `cfg_err` is 0, all counters are 0, and in the first cycle after reset all three enables are high.
- R2: `mode_pins` are captured on every clock edge while `rst` is high, and are ignored afterwards. The bus divisor is M/4 in mode 0, M/2 in modes 1 and 3, and M in mode 2, where M is 8 or 12 from the live multiplier setting.
- R3: The register layout is `wr_data[0]` for the multiplier (0 = x8, 1 = x12), `wr_data[1]` for the core ratio (0 = divide-by-1, 1 = divide-by-2) and `wr_data[3:2]` for the peripheral ratio (0 = /4, 1 = /6, 2 = /8, 3 = /12). Once an accepted write has been applied, `act_cfg` equals the written value.
- R4: A write is accepted only if core divisor <= bus divisor and peripheral divisor >= 2 x bus divisor. Both rules use the written multiplier and the latched mode. Equality is accepted.
- R5: A rejected write changes neither the live settings nor a pending accepted setting.
- R6: `cfg_err` becomes 1 the cycle after a rejected write and 0 the cycle after an accepted write. Without a write it holds its value.
- R7: A pending setting becomes live only on a clock edge where all three counters sit at their final count. In the cycle after that edge, all three enables are high together.
- R8: Each enable is high for exactly one reference cycle per divided period, in the cycle where its counter is 0. At divide-by-1 the enable stays high.
- R9: Each level output is high for floor(D/2) cycles from count 0 and then low for the rest of the period, where D is the divisor. At divide-by-1 the level stays high, and at divide-by-3 it is 1 cycle high and 2 cycles low.
- R10: If a second accepted write arrives before the pending one has been applied, it replaces the pending one. Only the later value becomes live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock (multiplied source) |
| rst | input | 1 | Synchronous active-high reset; mode pins are latched while high |
| mode_pins | input | 2 | Clock operating mode, 0 to 3 |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 4 | Register write value (layout in R3) |
| core_en | output | 1 | Core-domain enable pulse |
| bus_en | output | 1 | Bus-domain enable pulse |
| per_en | output | 1 | Peripheral-domain enable pulse |
| core_clk | output | 1 | Core-domain square-wave level |
| bus_clk | output | 1 | Bus-domain square-wave level |
| per_clk | output | 1 | Peripheral-domain square-wave level |
| cfg_err | output | 1 | Last write was rejected |
| act_cfg | output | 4 | Live register settings, same layout as `wr_data` |

## Verification
The embedded assertions check several rules on every cycle. Each counter stays below its divisor. The latched mode never moves outside reset. A rejected write leaves the pending slot untouched and raises the flag, and an accepted write clears it. Live settings change only on an apply edge, and that edge is always followed by a cycle with all three enables high. Only the bench's scenarios can show that the right ratio appears for each mode and multiplier, that duty cycles and pulse widths are correct, that defaults which break the rules in modes 1 and 2 still come up after reset, and that a second write replaces the first within one boundary window.

// File: rtl/mcr_clkdiv_pkg.sv
package mcr_clkdiv_pkg;

    localparam int DIV_W  = 5;
    localparam int MUL_LO = 8;
    localparam int MUL_HI = 12;

    typedef logic [DIV_W-1:0] div_t;
    typedef logic [1:0]       mode_t;

    // packed MSB first: wr_data[3:2] per_sel, [1] core_half, [0] mult_hi
    typedef struct packed {
        logic [1:0] per_sel;
        logic       core_half;
        logic       mult_hi;
    } freq_cfg_t;

    localparam freq_cfg_t CFG_RESET = '0;

    function automatic div_t mult_of(input freq_cfg_t c);
        div_t r;
        r = c.mult_hi ? div_t'(MUL_HI) : div_t'(MUL_LO);
        return r;
    endfunction

    function automatic div_t core_div_of(input freq_cfg_t c);
        div_t r;
        r = c.core_half ? div_t'(2) : div_t'(1);
        return r;
    endfunction

    function automatic div_t per_div_of(input freq_cfg_t c);
        div_t r;
        case (c.per_sel)
            2'd0:    r = div_t'(4);
            2'd1:    r = div_t'(6);
            2'd2:    r = div_t'(8);
            default: r = div_t'(12);
        endcase
        return r;
    endfunction

    function automatic div_t bus_div_of(input mode_t m, input freq_cfg_t c);
        div_t mv;
        div_t r;
        mv = mult_of(c);
        case (m)
            2'd0:    r = mv >> 2;
            2'd2:    r = mv;
            default: r = mv >> 1;
        endcase
        return r;
    endfunction

    function automatic logic cfg_legal(input mode_t m, input freq_cfg_t c);
        div_t bd;
        bd = bus_div_of(m, c);
        return (core_div_of(c) <= bd) && (per_div_of(c) >= (bd << 1));
    endfunction

endpackage

// File: rtl/mcr_div_counter.sv
module mcr_div_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] div_i,
    output logic         en_o,
    output logic         lvl_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign wrap_o = (st_q.cnt == div_i - ONE);
    assign en_o   = (st_q.cnt == '0);
    assign lvl_o  = (div_i == ONE) ? 1'b1 : (st_q.cnt < (div_i >> 1));

    always_comb begin
        st_d = st_q;
        if (rst || wrap_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R8: the count never reaches the divisor
    a_r8_cnt_below_div: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < div_i);

endmodule

// File: rtl/mcr_freq_ctrl.sv
module mcr_freq_ctrl
    import mcr_clkdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mode_t     mode_pins,
    input  logic      wr_en,
    input  freq_cfg_t wr_cfg,
    input  logic      boundary_i,
    output mode_t     mode_o,
    output freq_cfg_t act_o,
    output logic      err_o,
    output logic      apply_o
);

    typedef struct packed {
        mode_t     mode;
        freq_cfg_t act;
        freq_cfg_t pend;
        logic      pend_vld;
        logic      err;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     wr_ok;

    assign wr_ok   = cfg_legal(st_q.mode, wr_cfg);
    assign apply_o = boundary_i && st_q.pend_vld;
    assign mode_o  = st_q.mode;
    assign act_o   = st_q.act;
    assign err_o   = st_q.err;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.mode     = mode_pins;
            st_d.act      = CFG_RESET;
            st_d.pend     = CFG_RESET;
            st_d.pend_vld = 1'b0;
            st_d.err      = 1'b0;
        end else begin
            if (apply_o) begin
                st_d.act      = st_q.pend;
                st_d.pend_vld = 1'b0;
            end
            if (wr_en) begin
                if (wr_ok) begin
                    st_d.pend     = wr_cfg;
                    st_d.pend_vld = 1'b1;
                    st_d.err      = 1'b0;
                end else begin
                    st_d.err      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R2: latched mode is frozen once reset has ended
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(st_q.mode));

    // R5: a dropped write leaves the pending value alone
    a_r5_reject_keeps_pend: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ok) |=> $stable(st_q.pend));

    // R6: flag set by a dropped write
    a_r6_reject_sets_err: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ok) |=> st_q.err);

    // R6: flag cleared by a taken write, which is then pending
    a_r6_accept_clears_err: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ok) |=> (!st_q.err && st_q.pend_vld));

    // R6: flag holds without a write
    a_r6_err_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(st_q.err));

    // R7: live settings move only on an apply edge
    a_r7_act_only_on_apply: assert property (@(posedge clk) disable iff (rst)
        !apply_o |=> $stable(st_q.act));

    // R4: a waiting setting always obeys both rules
    a_r4_pend_legal: assert property (@(posedge clk) disable iff (rst)
        st_q.pend_vld |-> cfg_legal(st_q.mode, st_q.pend));

endmodule

// File: rtl/mcr_clock_divider.sv
module mcr_clock_divider (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    output logic       core_en,
    output logic       bus_en,
    output logic       per_en,
    output logic       core_clk,
    output logic       bus_clk,
    output logic       per_clk,
    output logic       cfg_err,
    output logic [3:0] act_cfg
);

    import mcr_clkdiv_pkg::*;

    localparam int NDOM = 3;   // 0 core, 1 bus, 2 peripheral

    mode_t          mode_q;
    freq_cfg_t      act_q;
    freq_cfg_t      wr_cfg;
    logic           apply;
    logic           boundary;
    div_t           div_arr [NDOM];
    logic [NDOM-1:0] en_v, lvl_v, wrap_v;

    assign wr_cfg   = freq_cfg_t'(wr_data);
    assign boundary = &wrap_v;

    always_comb begin
        div_arr[0] = core_div_of(act_q);
        div_arr[1] = bus_div_of(mode_q, act_q);
        div_arr[2] = per_div_of(act_q);
    end

    mcr_freq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_pins  (mode_pins),
        .wr_en      (wr_en),
        .wr_cfg     (wr_cfg),
        .boundary_i (boundary),
        .mode_o     (mode_q),
        .act_o      (act_q),
        .err_o      (cfg_err),
        .apply_o    (apply)
    );

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        mcr_div_counter #(.W(DIV_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .div_i  (div_arr[g]),
            .en_o   (en_v[g]),
            .lvl_o  (lvl_v[g]),
            .wrap_o (wrap_v[g])
        );
    end

    assign core_en  = en_v[0];
    assign bus_en   = en_v[1];
    assign per_en   = en_v[2];
    assign core_clk = lvl_v[0];
    assign bus_clk  = lvl_v[1];
    assign per_clk  = lvl_v[2];
    assign act_cfg  = act_q;

    // R7: after an apply edge every domain restarts together
    a_r7_enables_align: assert property (@(posedge clk) disable iff (rst)
        apply |=> (core_en && bus_en && per_en));

endmodule

// File: tb/mcr_clock_divider_tb.sv
module mcr_clock_divider_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_pins = 2'd0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic core_en, bus_en, per_en, core_clk, bus_clk, per_clk, cfg_err;
    logic [3:0] act_cfg;

    always #10 clk = ~clk;   // 50 MHz

    mcr_clock_divider u_dut (
        .clk(clk), .rst(rst), .mode_pins(mode_pins), .wr_en(wr_en), .wr_data(wr_data),
        .core_en(core_en), .bus_en(bus_en), .per_en(per_en),
        .core_clk(core_clk), .bus_clk(bus_clk), .per_clk(per_clk),
        .cfg_err(cfg_err), .act_cfg(act_cfg)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit model_live = 0;

    // behavioural reference state
    int       m_mode;
    logic [3:0] m_act, m_pend;
    bit       m_pvld, m_err;
    int       c_core, c_bus, c_per;
    int       dc, db, dp;
    bit       bnd;

    function automatic int mul_b(input logic [3:0] c);   return c[0] ? 12 : 8; endfunction
    function automatic int core_b(input logic [3:0] c);  return c[1] ? 2 : 1; endfunction
    function automatic int per_b(input logic [3:0] c);
        case (c[3:2])
            2'd0: return 4;
            2'd1: return 6;
            2'd2: return 8;
            default: return 12;
        endcase
    endfunction
    function automatic int bus_b(input int md, input logic [3:0] c);
        if (md == 0) return mul_b(c) / 4;
        if (md == 2) return mul_b(c);
        return mul_b(c) / 2;
    endfunction
    function automatic bit legal_b(input int md, input logic [3:0] c);
        return (core_b(c) <= bus_b(md, c)) && (per_b(c) >= 2 * bus_b(md, c));
    endfunction
    function automatic int lvl_b(input int cnt, input int d);
        if (d == 1) return 1;
        return (cnt < d / 2) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = int'(mode_pins);
            m_act = 4'd0; m_pend = 4'd0; m_pvld = 0; m_err = 0;
            c_core = 0; c_bus = 0; c_per = 0;
            model_live = 1;
        end else begin
            dc = core_b(m_act); db = bus_b(m_mode, m_act); dp = per_b(m_act);
            bnd = (c_core == dc - 1) && (c_bus == db - 1) && (c_per == dp - 1);
            c_core = (c_core == dc - 1) ? 0 : c_core + 1;
            c_bus  = (c_bus  == db - 1) ? 0 : c_bus + 1;
            c_per  = (c_per  == dp - 1) ? 0 : c_per + 1;
            if (bnd && m_pvld) begin
                m_act = m_pend;
                m_pvld = 0;
            end
            if (wr_en) begin
                if (legal_b(m_mode, wr_data)) begin
                    m_pend = wr_data; m_pvld = 1; m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (model_live && !rst && !finished) begin
            check("R8", "core_en", int'(core_en), int'(c_core == 0));
            check("R2", "bus_en",  int'(bus_en),  int'(c_bus == 0));
            check("R8", "per_en",  int'(per_en),  int'(c_per == 0));
            check("R9", "core_clk", int'(core_clk), lvl_b(c_core, core_b(m_act)));
            check("R9", "bus_clk",  int'(bus_clk),  lvl_b(c_bus, bus_b(m_mode, m_act)));
            check("R9", "per_clk",  int'(per_clk),  lvl_b(c_per, per_b(m_act)));
            check("R6", "cfg_err", int'(cfg_err), int'(m_err));
            check("R7", "act_cfg", int'(act_cfg), int'(m_act));
        end
    end

    task automatic do_reset(input logic [1:0] md);
        @(negedge clk);
        mode_pins = md;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_all_en;
        do @(negedge clk); while (!(core_en && bus_en && per_en));
    endtask

    task automatic bus_period(input string req, input int exp);
        int n;
        do @(negedge clk); while (!bus_en);
        n = 0;
        do begin @(negedge clk); n++; end while (!bus_en);
        check(req, "bus period", n, exp);
    endtask

    initial begin
        // R1: reset state in mode 0
        do_reset(2'd0);
        check("R1", "act_cfg after reset", int'(act_cfg), 0);
        check("R1", "cfg_err after reset", int'(cfg_err), 0);
        check("R1", "all enables after reset", int'(core_en && bus_en && per_en), 1);
        idle(25);
        // R2: pins move after reset, no effect
        mode_pins = 2'd2;
        idle(40);
        bus_period("R2", 2);
        mode_pins = 2'd0;

        // R3: x12, core /2, peripheral /12 -> bus /3
        wr(4'hF);
        idle(40);
        check("R3", "act_cfg after accept", int'(act_cfg), 15);
        bus_period("R9", 3);

        // R5/R6: peripheral /4 against bus /3 is dropped
        wr(4'b0011);
        check("R6", "err after reject", int'(cfg_err), 1);
        idle(30);
        check("R5", "act_cfg after reject", int'(act_cfg), 15);

        // R4: peripheral /6 equals twice bus /3, accepted
        wr(4'b0101);
        check("R6", "err after accept", int'(cfg_err), 0);
        idle(30);
        check("R4", "act_cfg equality", int'(act_cfg), 5);

        // R10: two writes inside one boundary window
        wait_all_en;
        wr(4'b1000);
        check("R7", "act before boundary", int'(act_cfg), 5);
        wr(4'b0110);
        idle(30);
        check("R10", "act after supersede", int'(act_cfg), 6);

        // mode 1: default applied even though it breaks the rules
        do_reset(2'd1);
        check("R1", "act_cfg after reset mode1", int'(act_cfg), 0);
        bus_period("R2", 4);
        wr(4'b0100);
        check("R5", "err mode1 per6", int'(cfg_err), 1);
        wr(4'b1000);
        check("R6", "err mode1 per8", int'(cfg_err), 0);
        idle(30);
        check("R3", "act mode1", int'(act_cfg), 8);
        wr(4'b1011);
        check("R5", "err mode1 x12 per8", int'(cfg_err), 1);
        wr(4'b1111);
        idle(40);
        check("R3", "act mode1 x12", int'(act_cfg), 15);
        bus_period("R2", 6);

        // mode 3 behaves like mode 1
        do_reset(2'd3);
        wr(4'b1000);
        idle(30);
        check("R2", "act mode3", int'(act_cfg), 8);

        // mode 2: bus /8, no write is legal
        do_reset(2'd2);
        bus_period("R2", 8);
        wr(4'b1100);
        check("R5", "err mode2", int'(cfg_err), 1);
        idle(30);
        check("R5", "act mode2", int'(act_cfg), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule